// File: doc/BRIEF.md
# Programmable Periodic Down-Counter Timer

This block is a 16-bit down-counting timer that sits on a simple word-addressed register bus. Software programs a start value and a control word. The counter then steps down by one on every prescaled tick of an external timer clock enable. When it reaches terminal count, either it reloads itself and keeps running (periodic), or it parks at zero (one-shot). Either way it latches an interrupt flag.

The interrupt flag stays set until software writes anything to the clear register. The interrupt output is the flag gated by an enable bit, so a masked timer still records its expirations. The live count can be read at any time, and elapsed ticks are the start value minus the read value. Register reads are combinational from registered state.

Top module: `dcnt_timer`

## Requirements
- R1: After reset the start register and the count both read 0xFFFF, the control register reads 0, and `irqOut` is low.
- R2: A write to word address 0 stores bits [15:0] of the write data and ignores the upper bits. On the next cycle the count equals that value and the prescaler has restarted from zero. A halted one-shot timer is also re-armed.
- R3: The count changes only on a prescaled tick. It holds while the enable bit (control bit 0) is 0, and it holds on cycles with `tickEn` low.
- R4: The prescale field is control bits [3:2]. The encoding 00 divides `tickEn` pulses by 1, 01 by 16, 10 by 256, and 11 by 1. With start value N, terminal count recurs every (N+1)×divisor enabled `tickEn` cycles.
- R5: With control bit 1 at 0 (periodic), a tick at count 0 reloads the count from the start register without any software action.
- R6: With control bit 1 at 1 (one-shot), a tick at count 0 sets the flag once. The count stays at 0 with no further expirations until the start register is written again.
- R7: The flag is set on every terminal-count tick, whatever the state of control bit 4. `irqOut` is the flag ANDed with control bit 4.
- R8: A write of any value to word address 3 clears the flag. If a terminal-count tick falls in the same cycle, the flag stays set.
- R9: Reads return the start register at address 0, the count at 1, and control bits [4:0] zero-extended at 2. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Timer clock enable, one pulse per timer input clock |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Word address (0 start, 1 count, 2 control, 3 clear) |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` |
| irqOut | output | 1 | Masked interrupt request |

## Verification
A wrong prescaler phase or count shows at the count read port within one prescaled tick. It therefore appears within at most 256 `tickEn` cycles of the fault. A wrong reload, a one-shot that does not halt, or a lost set-versus-clear priority shows on `irqOut` or on the count in the cycle right after the terminal tick. The reference model is therefore compared on both `rdData` and `irqOut` on every clock. Long stretches with a start value of 0 and frequent clear writes make the same-cycle set-and-clear case occur many times.

// File: rtl/dcnt_timer_pkg.sv
package dcnt_timer_pkg;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;
  localparam int CTRL_W = 5;
  localparam int PRE_W  = 8;

  localparam logic [ADDR_W-1:0] A_LOAD = 2'd0;
  localparam logic [ADDR_W-1:0] A_CNT  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;
  localparam logic [ADDR_W-1:0] A_CLR  = 2'd3;

  typedef struct packed {
    logic       loadWr;
    logic       run;
    logic       oneShot;
    logic [1:0] preSel;
  } tmrStrobe_t;
endpackage

// File: rtl/dcnt_timer_dp.sv
module dcnt_timer_dp
  import dcnt_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  tmrStrobe_t       strb,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLim;
  logic             halted;
  logic             active;
  logic             preHit;

  always_comb begin
    case (strb.preSel)
      2'b01:   preLim = PRE_W'(15);
      2'b10:   preLim = PRE_W'(255);
      default: preLim = '0;
    endcase
  end

  assign active = strb.run && !halted;
  assign preHit = preCnt >= preLim;
  assign expire = !strb.loadWr && active && tickEn && preHit && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '1;
      preCnt <= '0;
      halted <= 1'b0;
    end else if (strb.loadWr) begin
      cnt    <= loadVal;
      preCnt <= '0;
      halted <= 1'b0;
    end else if (active && tickEn) begin
      if (preHit) begin
        preCnt <= '0;
        if (cnt == '0) begin
          if (strb.oneShot) halted <= 1'b1;
          else              cnt    <= loadVal;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  // R3
  value_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.loadWr) |=> $stable(cnt));
  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadWr |=> (cnt == $past(loadVal)));
  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !strb.oneShot) |=> (cnt == $past(loadVal)));
  // R6
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (expire && strb.oneShot) |=> (cnt == '0));
endmodule

// File: rtl/dcnt_timer_regs.sv
module dcnt_timer_regs
  import dcnt_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              expire,
  input  logic [CNT_W-1:0]  cnt,
  output tmrStrobe_t        strb,
  output logic [CNT_W-1:0]  loadVal,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  logic [CNT_W-1:0]  loadReg;
  logic [CTRL_W-1:0] ctrlReg;
  logic              irqFlag;
  logic              loadWr;
  logic              clrWr;

  assign loadWr = wrEn && (addr == A_LOAD);
  assign clrWr  = wrEn && (addr == A_CLR);

  assign strb.loadWr  = loadWr;
  assign strb.run     = ctrlReg[0];
  assign strb.oneShot = ctrlReg[1];
  assign strb.preSel  = ctrlReg[3:2];
  assign loadVal      = loadWr ? wrData[CNT_W-1:0] : loadReg;
  assign irqOut       = irqFlag && ctrlReg[4];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadReg <= '1;
      ctrlReg <= '0;
      irqFlag <= 1'b0;
    end else begin
      if (loadWr) loadReg <= wrData[CNT_W-1:0];
      if (wrEn && (addr == A_CTRL)) ctrlReg <= wrData[CTRL_W-1:0];
      if (expire)     irqFlag <= 1'b1;
      else if (clrWr) irqFlag <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      A_LOAD:  rdData = DATA_W'(loadReg);
      A_CNT:   rdData = DATA_W'(cnt);
      A_CTRL:  rdData = DATA_W'(ctrlReg);
      default: rdData = '0;
    endcase
  end

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> irqFlag);
  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && !expire) |=> !irqFlag);
  // R8
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !clrWr) |=> irqFlag);
endmodule

// File: rtl/dcnt_timer.sv
module dcnt_timer
  import dcnt_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  tmrStrobe_t       strb;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] cnt;
  logic             expire;

  dcnt_timer_regs u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .expire(expire), .cnt(cnt), .strb(strb), .loadVal(loadVal),
    .rdData(rdData), .irqOut(irqOut)
  );

  dcnt_timer_dp u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strb(strb),
    .loadVal(loadVal), .cnt(cnt), .expire(expire)
  );
endmodule

// File: tb/dcnt_timer_tb.sv
module dcnt_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut;

  int    nCmp = 0;
  int    nBad = 0;
  bit    finished = 0;
  string tag = "R1";

  // behavioural reference state
  int mLoad = 'hFFFF, mVal = 'hFFFF, mCtrl = 0, mPre = 0;
  bit mFlag = 0, mDone = 0;

  always #2.5 clk = ~clk;

  dcnt_timer u_dut (.clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqOut(irqOut));

  function automatic int divOf(int sel);
    return (sel == 1) ? 16 : (sel == 2) ? 256 : 1;
  endfunction

  task automatic check();
    int expRd;
    bit expIrq;
    case (int'(addr))
      0: expRd = mLoad;
      1: expRd = mVal;
      2: expRd = mCtrl;
      default: expRd = 0;
    endcase
    expIrq = mFlag && mCtrl[4];
    nCmp++;
    if (rdData !== 32'(expRd) || irqOut !== expIrq) begin
      nBad++;
      $display("FAIL %s: addr=%0d rd=%h exp=%h irq=%b exp=%b", tag,
               addr, rdData, expRd, irqOut, expIrq);
    end
  endtask

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic step(bit wr, int a, int d, bit te);
    bit exp;
    int lim;
    wrEn = wr; addr = 2'(a); wrData = 32'(d); tickEn = te;
    exp = 0;
    lim = divOf((mCtrl >> 2) & 3) - 1;
    if (wr && a == 0) begin
      mLoad = d & 'hFFFF; mVal = mLoad; mPre = 0; mDone = 0;
    end else if (mCtrl[0] && !mDone && te) begin
      if (mPre >= lim) begin
        mPre = 0;
        if (mVal == 0) begin
          exp = 1;
          if (mCtrl[1]) mDone = 1; else mVal = mLoad;
        end else mVal = mVal - 1;
      end else mPre = mPre + 1;
    end
    if (wr && a == 2) mCtrl = d & 'h1F;
    if (exp) mFlag = 1; else if (wr && a == 3) mFlag = 0;
    @(posedge clk);
    @(negedge clk);
    check();
  endtask

  task automatic idle(int n, int a, bit te);
    for (int i = 0; i < n; i++) step(0, a, 0, te);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: expired, exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state through every address
    tag = "R1";
    for (int a = 0; a < 4; a++) idle(1, a, 1);
    // R9 read map, control readback
    tag = "R9";
    step(1, 2, 'hFFFF_FFE0, 0);
    idle(1, 2, 0);
    // R2 upper load bits ignored
    tag = "R2";
    step(1, 0, 'h0012_3456, 0);
    idle(1, 0, 0);
    idle(1, 1, 0);
    // R3 counting disabled / tickEn low
    tag = "R3";
    step(1, 0, 5, 0);
    idle(4, 1, 1);
    step(1, 2, 'h11, 0);
    idle(6, 1, 0);
    // R5 periodic div1, R7 irq enabled
    tag = "R5";
    idle(20, 1, 1);
    tag = "R8";
    step(1, 3, 'hABCD, 0);
    idle(2, 1, 0);
    // R4 div16 and div256 with gappy tickEn
    tag = "R4";
    step(1, 2, 'h15, 0);
    step(1, 0, 2, 0);
    for (int i = 0; i < 200; i++) step(0, 1, 0, (i % 3) != 0);
    step(1, 2, 'h19, 0);
    step(1, 0, 1, 0);
    idle(600, 1, 1);
    step(1, 2, 'h1D, 0);
    step(1, 0, 3, 0);
    idle(20, 1, 1);
    // R7 masked flag then unmask
    tag = "R7";
    step(1, 3, 0, 0);
    step(1, 2, 'h01, 0);
    step(1, 0, 1, 0);
    idle(5, 1, 1);
    step(1, 2, 'h11, 0);
    idle(2, 2, 0);
    // R6 one-shot halts, re-armed by load write
    tag = "R6";
    step(1, 3, 0, 0);
    step(1, 2, 'h13, 0);
    step(1, 0, 3, 0);
    idle(12, 1, 1);
    step(1, 3, 0, 1);
    idle(6, 1, 1);
    step(1, 0, 2, 1);
    idle(6, 1, 1);
    // R2 load write while running restarts
    tag = "R2";
    step(1, 2, 'h15, 0);
    step(1, 0, 4, 0);
    idle(9, 1, 1);
    step(1, 0, 7, 1);
    idle(20, 1, 1);
    // R8 frequent clears colliding with expirations (load 0)
    tag = "R8";
    step(1, 2, 'h11, 0);
    step(1, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom % 16);
      if (r < 4)       step(1, 3, int'($urandom), $urandom % 2 == 0);
      else if (r == 4) step(1, 2, int'($urandom), $urandom % 2 == 0);
      else if (r == 5) step(1, 0, int'($urandom % 8), $urandom % 2 == 0);
      else             step(0, int'($urandom % 4), 0, $urandom % 4 != 0);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule